// File: doc/BRIEF.md
# PCI Interrupt Routing Autodetect Controller

This block routes the four interrupt pins (A..D) of each PCI device attached to a host bridge onto four system interrupt outputs. Two routing schemes exist. A legacy pass-through scheme sends pin n straight to output n. A rotated scheme moves each pin around by an amount that depends on the device's slot. The rotated scheme has two variants, chosen by a variant-select input that reflects how the board is wired.

Which scheme applies is decided at run time. The block watches configuration-space write transactions. When software writes an interrupt-line register, the value it writes shows which mapping that software expects. A three-state mode register starts out undecided. The first telling write locks it into legacy or into rotated, and it then stays there until reset. A reset-time input can preload the mode for software whose behaviour is already known. The output is the OR of all device pins routed to each line, registered once.

Top module: `irq_route_top`

## Requirements
- R1: While `rst` is high, the mode loads from `init_mode`, encoded as 0 = undecided, 1 = legacy, 2 = rotated-locked, with 3 treated as undecided. `irq_out` is 0 on the cycle after reset.
- R2: Detection is considered only when all of the following hold: `cfg_wr_valid` is high, `cfg_wr_addr[7:0]` equals 0x3C, `alt_rot` is low, and the mode is undecided. Any other write leaves the mode unchanged.
- R3: The device number is `cfg_wr_addr[15:11]`, and the slot is that number modulo 4. The value examined is `cfg_wr_data[7:0]`. Higher data bits are ignored.
- R4: A value of 27 written for slot 2 leaves the mode undecided. A value of 27 for any other slot selects legacy.
- R5: A value equal to slot+27, or equal to slot+91, selects legacy.
- R6: Any other value selects rotated-locked.
- R7: Once the mode is legacy or rotated-locked, no write changes it until the next reset.
- R8: In legacy mode, pin n of every device drives output n.
- R9: In the undecided and rotated-locked modes, pin n of a device in slot s drives output (s+n+2) mod 4. When `alt_rot` is high, it drives output (s+n+3) mod 4.
- R10: Each output bit is the OR of all pins routed to it, registered one clock after the pins. A mode change made by a write at clock edge k first affects routing at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 2 | Mode loaded during reset |
| alt_rot | input | 1 | Rotation variant select; also disables detection |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W (24) | Configuration write address |
| cfg_wr_data | input | DATA_W (32) | Configuration write data |
| dev_pins | input | NUM_DEV*4 (8) | Interrupt pins, four per device, device 0 in the low nibble |
| irq_out | output | 4 | Routed system interrupt lines |

## Verification
Two things can happen in the same cycle: a detecting write that changes the mode, and a change on the device pins that must be routed. The bench drives a deciding interrupt-line write and a new pin pattern on the same falling edge. It then checks that the first registered output still uses the rotated scheme and that the following one uses the legacy scheme. The table walk also separates the undecided mode from the rotated-locked mode, which route identically, by issuing a second write of 27 after every vector and checking whether the routing flips.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    MODE_PROBE  = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FIXED  = 2'd2
  } route_mode_e;

  localparam int PINS_PER_DEV = 4;
  localparam int DEVNUM_W     = 5;

  // Code 3 on the preload input is folded onto the undecided state.
  function automatic route_mode_e decode_init(input logic [1:0] code);
    case (code)
      2'd1:    return MODE_LEGACY;
      2'd2:    return MODE_FIXED;
      default: return MODE_PROBE;
    endcase
  endfunction

  // Target output for pin n of a device in slot s.
  function automatic logic [1:0] pin_target(input logic [1:0] slot,
                                            input logic [1:0] pin,
                                            input logic       legacy,
                                            input logic       alt);
    logic [1:0] rot;
    rot = alt ? 2'd3 : 2'd2;
    return legacy ? pin : (slot + pin + rot);
  endfunction

endpackage

// File: rtl/irq_line_classify.sv
module irq_line_classify
  import irq_route_pkg::*;
#(
  parameter int VAL_W      = 8,
  parameter int BASE_LINE  = 27,
  parameter int HIGH_OFS   = 64,
  parameter int SHARE_SLOT = 2
) (
  input  logic [1:0]       slot,
  input  logic [VAL_W-1:0] line_val,
  output route_mode_e      verdict
);

  localparam logic [VAL_W-1:0] BASE_V = VAL_W'(BASE_LINE);
  localparam logic [VAL_W-1:0] HIGH_V = VAL_W'(HIGH_OFS);

  logic [VAL_W-1:0] swz_v;
  logic [VAL_W-1:0] swz_hi_v;

  assign swz_v    = BASE_V + VAL_W'(slot);
  assign swz_hi_v = swz_v + HIGH_V;

  always_comb begin
    if (line_val == BASE_V)
      verdict = (slot == 2'(SHARE_SLOT)) ? MODE_PROBE : MODE_LEGACY;
    else if (line_val == swz_v || line_val == swz_hi_v)
      verdict = MODE_LEGACY;
    else
      verdict = MODE_FIXED;
  end

endmodule

// File: rtl/irq_mode_track.sv
module irq_mode_track
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  init_mode,
  input  logic        wr_valid,
  input  logic        ofs_match,
  input  logic        alt_rot,
  input  route_mode_e verdict,
  output route_mode_e mode_q
);

  logic probe_hit;
  assign probe_hit = wr_valid && ofs_match && !alt_rot && (mode_q == MODE_PROBE);

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= decode_init(init_mode);
    else if (probe_hit)
      mode_q <= verdict;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3);                                                       // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_PROBE) |=> $stable(mode_q));                           // R7
  AST_ALT_NO_DETECT: assert property (@(posedge clk) disable iff (rst)
    alt_rot |=> $stable(mode_q));                                          // R2
  AST_OFS_FILTER: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid || !ofs_match) |=> $stable(mode_q));                        // R2

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
  import irq_route_pkg::*;
#(
  parameter int                            NUM_DEV  = 2,
  parameter logic [NUM_DEV*DEVNUM_W-1:0]   DEV_NUMS = {5'd13, 5'd11}
) (
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] pins,
  input  logic                            legacy,
  input  logic                            alt,
  output logic [PINS_PER_DEV-1:0]         route
);

  logic [PINS_PER_DEV-1:0] contrib [NUM_DEV];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [1:0] SLOT = DEV_NUMS[d*DEVNUM_W +: 2];
    always_comb begin
      contrib[d] = '0;
      for (int n = 0; n < PINS_PER_DEV; n++) begin
        if (pins[d*PINS_PER_DEV + n])
          contrib[d][pin_target(SLOT, 2'(n), legacy, alt)] = 1'b1;
      end
    end
  end

  always_comb begin
    route = '0;
    for (int d = 0; d < NUM_DEV; d++) route = route | contrib[d];
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int                          ADDR_W   = 24,
  parameter int                          DATA_W   = 32,
  parameter int                          NUM_DEV  = 2,
  parameter logic [NUM_DEV*DEVNUM_W-1:0] DEV_NUMS = {5'd13, 5'd11},
  parameter logic [7:0]                  LINE_OFS = 8'h3C
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [1:0]                      init_mode,
  input  logic                            alt_rot,
  input  logic                            cfg_wr_valid,
  input  logic [ADDR_W-1:0]               cfg_wr_addr,
  input  logic [DATA_W-1:0]               cfg_wr_data,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] dev_pins,
  output logic [PINS_PER_DEV-1:0]         irq_out
);

  localparam int SLOT_LSB = 11;

  route_mode_e             mode_q;
  route_mode_e             verdict;
  logic                    ofs_match;
  logic [PINS_PER_DEV-1:0] route;

  assign ofs_match = (cfg_wr_addr[7:0] == LINE_OFS);

  irq_line_classify #(.VAL_W(8)) u_cls (
    .slot     (cfg_wr_addr[SLOT_LSB +: 2]),
    .line_val (cfg_wr_data[7:0]),
    .verdict  (verdict)
  );

  irq_mode_track u_mode (
    .clk       (clk),
    .rst       (rst),
    .init_mode (init_mode),
    .wr_valid  (cfg_wr_valid),
    .ofs_match (ofs_match),
    .alt_rot   (alt_rot),
    .verdict   (verdict),
    .mode_q    (mode_q)
  );

  irq_pin_router #(.NUM_DEV(NUM_DEV), .DEV_NUMS(DEV_NUMS)) u_rt (
    .pins   (dev_pins),
    .legacy (mode_q == MODE_LEGACY),
    .alt    (alt_rot),
    .route  (route)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= route;
  end

  AST_QUIET_IN: assert property (@(posedge clk) disable iff (rst)
    (dev_pins == '0) |=> (irq_out == '0));                                 // R10
  AST_OUT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(irq_out) <= $countones($past(dev_pins))));        // R10
  AST_LEGACY_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LEGACY && dev_pins[3:0] != 4'd0) |=> (irq_out != 4'd0)); // R8

endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  init_mode = 2'd0;
  logic        alt_rot = 1'b0;
  logic        cfg_wr_valid = 1'b0;
  logic [23:0] cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [7:0]  dev_pins = '0;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst(rst), .init_mode(init_mode), .alt_rot(alt_rot),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .dev_pins(dev_pins), .irq_out(irq_out)
  );

  // Device 0 is number 11 (slot 3), device 1 is number 13 (slot 1).
  localparam logic [1:0] SL0 = 2'd3;
  localparam logic [1:0] SL1 = 2'd1;

  typedef struct packed {
    logic [1:0]  init;
    logic        alt;
    logic        vld;
    logic [4:0]  dev;
    logic [7:0]  ofs;
    logic [15:0] data;
    logic [1:0]  expm;
  } vec_t;

  localparam int NV = 18;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 5'd2,  8'h3C, 16'd27,    2'd0}, // R4 slot 2 keeps undecided
    {2'd0, 1'b0, 1'b1, 5'd6,  8'h3C, 16'd27,    2'd0}, // R3 dev 6 is slot 2
    {2'd0, 1'b0, 1'b1, 5'd0,  8'h3C, 16'd27,    2'd1}, // R4
    {2'd0, 1'b0, 1'b1, 5'd1,  8'h3C, 16'd27,    2'd1}, // R4
    {2'd0, 1'b0, 1'b1, 5'd1,  8'h3C, 16'd28,    2'd1}, // R5
    {2'd0, 1'b0, 1'b1, 5'd3,  8'h3C, 16'd30,    2'd1}, // R5
    {2'd0, 1'b0, 1'b1, 5'd9,  8'h3C, 16'd28,    2'd1}, // R3 dev 9 is slot 1
    {2'd0, 1'b0, 1'b1, 5'd2,  8'h3C, 16'd93,    2'd1}, // R5
    {2'd0, 1'b0, 1'b1, 5'd7,  8'h3C, 16'd94,    2'd1}, // R5
    {2'd0, 1'b0, 1'b1, 5'd1,  8'h3C, 16'd91,    2'd2}, // R6 off by one slot
    {2'd0, 1'b0, 1'b1, 5'd0,  8'h3C, 16'd50,    2'd2}, // R6
    {2'd0, 1'b0, 1'b1, 5'd0,  8'h3D, 16'd27,    2'd0}, // R2 wrong offset
    {2'd0, 1'b1, 1'b1, 5'd0,  8'h3C, 16'd27,    2'd0}, // R2 alt blocks detection
    {2'd0, 1'b0, 1'b0, 5'd0,  8'h3C, 16'd27,    2'd0}, // R2 no strobe
    {2'd1, 1'b0, 1'b1, 5'd0,  8'h3C, 16'd50,    2'd1}, // R1 preload legacy
    {2'd2, 1'b0, 1'b1, 5'd0,  8'h3C, 16'd27,    2'd2}, // R1 preload locked
    {2'd3, 1'b0, 1'b1, 5'd0,  8'h3C, 16'd50,    2'd2}, // R1 code 3 is undecided
    {2'd0, 1'b0, 1'b1, 5'd0,  8'h3C, 16'h011B,  2'd1}  // R3 upper data ignored
  };

  function automatic logic [3:0] exp_route(input logic [1:0] m, input logic a,
                                           input logic [7:0] p);
    logic [3:0] r = '0;
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 4; n++) begin
        if (p[d*4+n]) begin
          int s = (d == 0) ? int'(SL0) : int'(SL1);
          if (m == 2'd1) r[n] = 1'b1;
          else           r[(s + n + (a ? 3 : 2)) % 4] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] im, input logic a);
    @(negedge clk);
    rst = 1'b1; init_mode = im; alt_rot = a; dev_pins = '0; cfg_wr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic v, input logic [4:0] dev, input logic [7:0] ofs,
                    input logic [15:0] data);
    @(negedge clk);
    cfg_wr_valid = v;
    cfg_wr_addr  = {8'h00, dev, 3'b000, ofs};
    cfg_wr_data  = {16'h0, data};
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic pins_check(input string tag, input logic [7:0] p,
                            input logic [1:0] m, input logic a);
    @(negedge clk);
    dev_pins = p;
    @(posedge clk);
    #1;
    chk(tag, irq_out, exp_route(m, a, p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state with pins active during reset
    @(negedge clk);
    rst = 1'b1; dev_pins = 8'hFF;
    @(posedge clk); #1;
    chk("R1 output cleared in reset", irq_out, 4'b0000);
    dev_pins = 8'h00;
    @(negedge clk); rst = 1'b0;

    // Table walk: write, route check, then lock probe with a second 27
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [1:0] m2;
      v = vec_t'(VEC[i]);
      do_reset(v.init, v.alt);
      wr(v.vld, v.dev, v.ofs, v.data);
      pins_check($sformatf("R9 vec %0d route A", i), 8'h01, v.expm, v.alt);   // R8 R9
      pins_check($sformatf("R9 vec %0d route B", i), 8'hA5, v.expm, v.alt);
      m2 = (v.expm == 2'd0 && !v.alt) ? 2'd1 : v.expm;
      wr(1'b1, 5'd0, 8'h3C, 16'd27);
      pins_check($sformatf("R7 vec %0d after second 27", i), 8'h01, m2, v.alt);
    end

    // R7: locked rotated stays after many telling writes
    do_reset(2'd0, 1'b0);
    wr(1'b1, 5'd0, 8'h3C, 16'd60);
    wr(1'b1, 5'd0, 8'h3C, 16'd27);
    wr(1'b1, 5'd1, 8'h3C, 16'd92);
    pins_check("R7 rotated lock holds", 8'h0F, 2'd2, 1'b0);

    // R7: locked legacy stays after an otherwise-neutral value
    do_reset(2'd0, 1'b0);
    wr(1'b1, 5'd3, 8'h3C, 16'd94);
    wr(1'b1, 5'd0, 8'h3C, 16'd77);
    pins_check("R7 legacy lock holds", 8'h12, 2'd1, 1'b0);

    // R8 legacy pass-through of every pin
    for (int n = 0; n < 4; n++)
      pins_check("R8 legacy pin", 8'(1 << n), 2'd1, 1'b0);

    // R10 OR merge: dev0 pin0 and dev1 pin2 both land on output 1
    do_reset(2'd0, 1'b0);
    pins_check("R10 merged pair", 8'h41, 2'd0, 1'b0);
    chk("R10 merged value", irq_out, 4'b0010);
    pins_check("R10 one of pair", 8'h40, 2'd0, 1'b0);

    // R10 register latency: output holds until the next edge
    @(negedge clk);
    dev_pins = 8'h00;
    #1;
    chk("R10 output not yet updated", irq_out, 4'b0010);
    @(posedge clk); #1;
    chk("R10 output after edge", irq_out, 4'b0000);

    // R10 mode change and pin change in the same cycle
    do_reset(2'd0, 1'b0);
    @(negedge clk);
    cfg_wr_valid = 1'b1;
    cfg_wr_addr  = {8'h00, 5'd0, 3'b000, 8'h3C};
    cfg_wr_data  = 32'd27;
    dev_pins     = 8'h01;
    @(posedge clk); #1;
    chk("R10 same-cycle uses old mode", irq_out, exp_route(2'd0, 1'b0, 8'h01));
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    @(posedge clk); #1;
    chk("R10 next cycle uses new mode", irq_out, exp_route(2'd1, 1'b0, 8'h01));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule